// File: doc/BRIEF.md
# Flash Reset and Power-Down Sequencer

This block drives what happens when a flash device's active-low reset/power-down pin is used. If the pin stays low long enough while the memory is idle, the device drops into deep power-down. In that state the outputs float, and reads and writes are held off. When the pin goes high again, the block enters a recovery period. A single counter in that period first raises a read-ready flag and later a write-ready flag. A one-cycle pulse on entry to recovery returns the command interface to array-read mode and presets the status register to 0x80.

If the pin falls while the program/erase engine reports busy, the block asks the engine to abort. It then runs a shutdown interval of fixed length, counted from the first low sample. When that interval ends, the pin level decides the path. A high pin leads straight to recovery. A low pin leads to power-down. In both cases the recovery delays count from the end of the shutdown interval, not from the time the pin went high. A sticky flag records that the last operation was cut short, so the aborted location or block can be reported as invalid. The flag clears when the next program or erase completes successfully.

All delays are cycle-count parameters. The pin input is assumed to be already synchronised to `clk`, and `porN` is the power-on reset of the sequencer's own flops.

Top module: `pwrdn_seq`

## Requirements
- R1: While `porN` is low, and on leaving it, the outputs are: `abortReq`=0, `outDisable`=0, `cuiRstPulse`=0, `readReady`=1, `writeReady`=1, `abortedFlag`=0.
- R2: While the engine is not busy, a low run on `pinRstN` of fewer than `MIN_PULSE_CYC` consecutive sampled cycles leaves every output unchanged.
- R3: While the engine is not busy, `MIN_PULSE_CYC` consecutive low samples of `pinRstN` enter power-down. The block shows `outDisable`=1 with `readReady`=`writeReady`=0 in the cycle after the last of those samples, and stays that way while the pin stays low.
- R4: A low sample of `pinRstN` while idle with `engineBusy`=1 raises `abortReq` from the next cycle for exactly `SHUTDOWN_CYC` cycles. Both ready flags stay 0 and `outDisable` stays 1 during that time, whatever the pin does.
- R5: If the pin is sampled high at the last shutdown cycle, the block enters recovery in the next cycle. If it is sampled low, the block enters power-down and leaves it one cycle after the pin is sampled high.
- R6: In recovery, `readReady` rises `READ_REC_CYC` cycles after entry and `writeReady` rises `WRITE_REC_CYC` cycles after entry. `outDisable` is the inverse of `readReady`. After both delays have elapsed, the block returns to idle with both flags still 1.
- R7: After an abort, the recovery delays are counted from the end of the shutdown interval, even when the pin rose early in that interval.
- R8: `cuiRstPulse` is high for exactly one cycle: the first cycle of each recovery, which is when the command interface goes to array-read mode and the status register is preset to 0x80.
- R9: `abortedFlag` rises together with `abortReq` and stays set through recovery. It is cleared one cycle after an `opDone` pulse that is sampled while idle.
- R10: `MIN_PULSE_CYC` consecutive low samples during recovery return the block to power-down. The ready flags are cleared in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| porN | input | 1 | Active-low power-on reset of the sequencer flops |
| pinRstN | input | 1 | Synchronised active-low reset/power-down pin level |
| engineBusy | input | 1 | Program/erase engine is running an operation |
| opDone | input | 1 | One-cycle pulse: a program or erase finished successfully |
| abortReq | output | 1 | Request to the engine to abort, high during shutdown |
| outDisable | output | 1 | Forces the data outputs to high impedance |
| cuiRstPulse | output | 1 | One-cycle reset of the command interface and status register |
| readReady | output | 1 | Array reads may be served |
| writeReady | output | 1 | Command writes may be accepted |
| abortedFlag | output | 1 | Sticky: the last operation was aborted |

## Verification
Every result falls due a fixed number of cycles after its stimulus. Power-down entry follows `MIN_PULSE_CYC` low samples. `abortReq` comes one cycle after a busy low sample and lasts `SHUTDOWN_CYC` cycles. Recovery begins one cycle after the deciding sample, and the ready flags follow `READ_REC_CYC` and `WRITE_REC_CYC` cycles into recovery. The driver changes inputs just after a rising edge and tags each expected output vector with the absolute cycle number in which it must appear. The monitor compares on the falling edge of exactly that cycle. Each limit is checked on both sides, one cycle before and in the cycle due, so an off-by-one in any counter shows up.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ABORTING  = 2'd1,
    ST_POWERDOWN = 2'd2,
    ST_RECOVERY  = 2'd3
  } seq_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic lowRun;     // count consecutive low pin samples
    logic shutRun;    // count shutdown interval
    logic recRun;     // count recovery interval
    logic setAbort;   // set sticky aborted flag
    logic clrAbort;   // clear sticky aborted flag
    logic firePulse;  // launch command-interface reset pulse
  } seq_strobes_t;

  // datapath -> control flags
  typedef struct packed {
    logic lowDone;
    logic shutDone;
    logic readOk;
    logic writeOk;
    logic recDone;
  } dp_flags_t;

endpackage

// File: rtl/pwrdn_seq_cnt.sv
module pwrdn_seq_cnt #(
  parameter int LIMIT = 4,
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         atLimit
);

  localparam logic [W-1:0] LAST = W'(LIMIT);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign atLimit = (cnt == LAST);

endmodule

// File: rtl/pwrdn_seq_dp.sv
module pwrdn_seq_dp
  import pwrdn_seq_pkg::*;
#(
  parameter int MIN_PULSE_CYC = 16,
  parameter int SHUTDOWN_CYC  = 24,
  parameter int READ_REC_CYC  = 10,
  parameter int WRITE_REC_CYC = 20
) (
  input  logic         clk,
  input  logic         porN,
  input  seq_strobes_t strb,
  output dp_flags_t    flags,
  output logic         cuiPulse,
  output logic         abortFlag
);

  localparam int REC_MAX = (READ_REC_CYC > WRITE_REC_CYC) ? READ_REC_CYC : WRITE_REC_CYC;
  localparam int REC_W   = $clog2(REC_MAX + 1);
  localparam logic [REC_W-1:0] READ_TH  = REC_W'(READ_REC_CYC);
  localparam logic [REC_W-1:0] WRITE_TH = REC_W'(WRITE_REC_CYC);

  logic [REC_W-1:0] recCnt;
  logic             recAtMax;
  logic             lowAt;
  logic             shutAt;

  // consecutive low-sample counter; the pin low this cycle makes it MIN_PULSE_CYC
  pwrdn_seq_cnt #(.LIMIT(MIN_PULSE_CYC - 1)) lowCnt_i (
    .clk(clk), .porN(porN), .run(strb.lowRun), .cnt(), .atLimit(lowAt)
  );

  // shutdown interval counter, SHUTDOWN_CYC cycles long
  pwrdn_seq_cnt #(.LIMIT(SHUTDOWN_CYC - 1)) shutCnt_i (
    .clk(clk), .porN(porN), .run(strb.shutRun), .cnt(), .atLimit(shutAt)
  );

  // one recovery counter serves both thresholds
  pwrdn_seq_cnt #(.LIMIT(REC_MAX)) recCnt_i (
    .clk(clk), .porN(porN), .run(strb.recRun), .cnt(recCnt), .atLimit(recAtMax)
  );

  always_comb begin
    flags.lowDone  = lowAt && strb.lowRun;
    flags.shutDone = shutAt && strb.shutRun;
    flags.readOk   = strb.recRun && (recCnt >= READ_TH);
    flags.writeOk  = strb.recRun && (recCnt >= WRITE_TH);
    flags.recDone  = strb.recRun && recAtMax;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cuiPulse  <= 1'b0;
      abortFlag <= 1'b0;
    end else begin
      cuiPulse <= strb.firePulse;
      if (strb.setAbort) begin
        abortFlag <= 1'b1;
      end else if (strb.clrAbort) begin
        abortFlag <= 1'b0;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!porN)
    cuiPulse |=> !cuiPulse); // R8

  AST_SHUT_NOT_EARLY: assert property (@(posedge clk) disable iff (!porN)
    (strb.shutRun && !$past(strb.shutRun)) |-> !flags.shutDone || (SHUTDOWN_CYC == 1)); // R4

endmodule

// File: rtl/pwrdn_seq_ctrl.sv
module pwrdn_seq_ctrl
  import pwrdn_seq_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         pinRstN,
  input  logic         engineBusy,
  input  logic         opDone,
  input  dp_flags_t    flags,
  output seq_strobes_t strb,
  output logic         abortReq,
  output logic         readReady,
  output logic         writeReady
);

  seq_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (!pinRstN && engineBusy)    nxt = ST_ABORTING;
        else if (flags.lowDone)        nxt = ST_POWERDOWN;
      end
      ST_ABORTING: begin
        if (flags.shutDone)            nxt = pinRstN ? ST_RECOVERY : ST_POWERDOWN;
      end
      ST_POWERDOWN: begin
        if (pinRstN)                   nxt = ST_RECOVERY;
      end
      ST_RECOVERY: begin
        if (!pinRstN && engineBusy)    nxt = ST_ABORTING;
        else if (flags.lowDone)        nxt = ST_POWERDOWN;
        else if (flags.recDone)        nxt = ST_IDLE;
      end
      default:                         nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb.lowRun    = !pinRstN && (state == ST_IDLE || state == ST_RECOVERY);
    strb.shutRun   = (state == ST_ABORTING);
    strb.recRun    = (state == ST_RECOVERY);
    strb.setAbort  = (nxt == ST_ABORTING) && (state != ST_ABORTING);
    strb.clrAbort  = (state == ST_IDLE) && opDone;
    strb.firePulse = (nxt == ST_RECOVERY) && (state != ST_RECOVERY);
  end

  assign abortReq   = (state == ST_ABORTING);
  assign readReady  = (state == ST_IDLE) || flags.readOk;
  assign writeReady = (state == ST_IDLE) || flags.writeOk;

  AST_ABORT_ON_BUSY: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_IDLE && !pinRstN && engineBusy) |=> abortReq); // R4

  AST_ABORT_LEN: assert property (@(posedge clk) disable iff (!porN)
    $fell(abortReq) |-> $past(flags.shutDone)); // R4

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_POWERDOWN && !pinRstN) |=> (state == ST_POWERDOWN && !readReady)); // R3

  AST_PD_EXIT: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_POWERDOWN && pinRstN) |=> (state == ST_RECOVERY)); // R5

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_seq_pkg::*;
#(
  parameter int MIN_PULSE_CYC = 16,
  parameter int SHUTDOWN_CYC  = 24,
  parameter int READ_REC_CYC  = 10,
  parameter int WRITE_REC_CYC = 20
) (
  input  logic clk,
  input  logic porN,
  input  logic pinRstN,
  input  logic engineBusy,
  input  logic opDone,
  output logic abortReq,
  output logic outDisable,
  output logic cuiRstPulse,
  output logic readReady,
  output logic writeReady,
  output logic abortedFlag
);

  seq_strobes_t strb;
  dp_flags_t    flags;

  pwrdn_seq_ctrl ctrl_i (
    .clk(clk), .porN(porN), .pinRstN(pinRstN), .engineBusy(engineBusy),
    .opDone(opDone), .flags(flags), .strb(strb), .abortReq(abortReq),
    .readReady(readReady), .writeReady(writeReady)
  );

  pwrdn_seq_dp #(
    .MIN_PULSE_CYC(MIN_PULSE_CYC), .SHUTDOWN_CYC(SHUTDOWN_CYC),
    .READ_REC_CYC(READ_REC_CYC), .WRITE_REC_CYC(WRITE_REC_CYC)
  ) dp_i (
    .clk(clk), .porN(porN), .strb(strb), .flags(flags),
    .cuiPulse(cuiRstPulse), .abortFlag(abortedFlag)
  );

  assign outDisable = !readReady;

  AST_STICKY_WITH_ABORT: assert property (@(posedge clk) disable iff (!porN)
    $rose(abortedFlag) |-> abortReq); // R9

  AST_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!porN)
    cuiRstPulse |-> (!writeReady && !abortReq)); // R8

  generate
    if (WRITE_REC_CYC >= READ_REC_CYC) begin : g_order
      AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!porN)
        writeReady |-> readReady); // R6
    end
  endgenerate

endmodule

// File: tb/pwrdn_seq_tb_top.sv
`timescale 1ns/1ps
module pwrdn_seq_tb_top;

  localparam int MP = 4;
  localparam int SH = 6;
  localparam int RR = 3;
  localparam int WR = 5;

  // vector order: {abortReq, outDisable, cuiRstPulse, readReady, writeReady, abortedFlag}
  localparam logic [5:0] IDLE_V = 6'b000110;
  localparam logic [5:0] ALL    = 6'b111111;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic pinRstN = 1'b1;
  logic engineBusy = 1'b0;
  logic opDone = 1'b0;
  logic abortReq, outDisable, cuiRstPulse, readReady, writeReady, abortedFlag;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int         at;
    logic [5:0] val;
    logic [5:0] mask;
    string      req;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrdn_seq #(
    .MIN_PULSE_CYC(MP), .SHUTDOWN_CYC(SH), .READ_REC_CYC(RR), .WRITE_REC_CYC(WR)
  ) dut_i (
    .clk(clk), .porN(porN), .pinRstN(pinRstN), .engineBusy(engineBusy), .opDone(opDone),
    .abortReq(abortReq), .outDisable(outDisable), .cuiRstPulse(cuiRstPulse),
    .readReady(readReady), .writeReady(writeReady), .abortedFlag(abortedFlag)
  );

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    logic [5:0] act;
    act = {abortReq, outDisable, cuiRstPulse, readReady, writeReady, abortedFlag};
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        checks++;
        if ((act & expQ[i].mask) !== (expQ[i].val & expQ[i].mask)) begin
          failures++;
          $display("FAIL %s cycle %0d actual=%b expected=%b mask=%b",
                   expQ[i].req, cyc, act, expQ[i].val, expQ[i].mask);
        end
        expQ.delete(i);
      end
    end
  end

  task automatic expectAt(input int off, input logic [5:0] v, input logic [5:0] m, input string r);
    exp_t e;
    e.at = cyc + off; e.val = v; e.mask = m; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    step(2);
    expectAt(0, IDLE_V, ALL, "R1 in reset");
    step(1);
    porN = 1'b1;
    expectAt(1, IDLE_V, ALL, "R1 after reset");
    step(4);

    // R2: short pulse of MP-1 low samples ignored
    pinRstN = 1'b0;
    for (int k = 1; k <= 5; k++) expectAt(k, IDLE_V, ALL, "R2 short pulse");
    step(MP - 1);
    pinRstN = 1'b1;
    step(8);

    // R3: qualified pulse enters power-down, then R5/R6/R8 on exit
    pinRstN = 1'b0;
    expectAt(MP - 1, IDLE_V, ALL, "R3 one before limit");
    expectAt(MP, 6'b010000, ALL, "R3 power-down entry");
    expectAt(MP + 5, 6'b010000, ALL, "R3 power-down held");
    step(10);
    pinRstN = 1'b1;
    expectAt(0, 6'b010000, ALL, "R5 still down at rise");
    expectAt(1, 6'b011000, ALL, "R8 pulse on recovery entry");
    expectAt(2, 6'b010000, ALL, "R8 pulse single");
    expectAt(RR, 6'b010000, ALL, "R6 read not yet");
    expectAt(RR + 1, 6'b000100, ALL, "R6 read ready");
    expectAt(WR, 6'b000100, ALL, "R6 write not yet");
    expectAt(WR + 1, IDLE_V, ALL, "R6 write ready");
    expectAt(WR + 4, IDLE_V, ALL, "R6 back to idle");
    step(12);

    // R4/R5/R7/R9: abort with early pin rise
    engineBusy = 1'b1;
    pinRstN = 1'b0;
    expectAt(0, IDLE_V, ALL, "R4 before abort");
    for (int k = 1; k <= SH; k++) expectAt(k, 6'b110001, ALL, "R4 abort window");
    expectAt(SH + 1, 6'b011001, ALL, "R5 recovery after shutdown");
    expectAt(SH + 1 + RR - 1, 6'b010001, ALL, "R7 read delay from shutdown end");
    expectAt(SH + 1 + RR, 6'b000101, ALL, "R7 read ready");
    expectAt(SH + 1 + WR - 1, 6'b000101, ALL, "R7 write delay from shutdown end");
    expectAt(SH + 1 + WR, 6'b000111, ALL, "R7 write ready");
    expectAt(SH + 1 + WR + 2, 6'b000111, ALL, "R9 flag sticky in idle");
    step(2);
    engineBusy = 1'b0;
    pinRstN = 1'b1;
    step(SH + WR + 4);
    opDone = 1'b1;
    expectAt(0, 6'b000111, ALL, "R9 flag before clear");
    expectAt(1, IDLE_V, ALL, "R9 flag cleared");
    step(1);
    opDone = 1'b0;
    step(4);

    // R5: pin still low at end of shutdown -> power-down
    engineBusy = 1'b1;
    pinRstN = 1'b0;
    expectAt(SH, 6'b110001, ALL, "R4 last abort cycle");
    expectAt(SH + 1, 6'b010001, ALL, "R5 power-down after shutdown");
    expectAt(SH + 5, 6'b010001, ALL, "R5 power-down held");
    step(2);
    engineBusy = 1'b0;
    step(SH + 4);
    pinRstN = 1'b1;
    expectAt(1, 6'b011001, ALL, "R8 pulse after abort power-down");
    expectAt(1 + RR, 6'b000101, ALL, "R6 read after power-down exit");
    expectAt(1 + WR, 6'b000111, ALL, "R6 write after power-down exit");
    step(WR + 4);
    opDone = 1'b1;
    step(1);
    opDone = 1'b0;
    step(3);

    // R10: low pulse during recovery returns to power-down
    pinRstN = 1'b0;
    step(MP + 2);
    pinRstN = 1'b1;
    step(1);
    pinRstN = 1'b0;
    expectAt(0, 6'b011000, ALL, "R8 pulse before re-entry");
    expectAt(MP - 1, 6'b000100, ALL, "R10 recovery still running");
    expectAt(MP, 6'b010000, ALL, "R10 power-down re-entered");
    step(MP + 3);
    pinRstN = 1'b1;
    expectAt(WR + 3, IDLE_V, ALL, "R10 final idle");
    step(WR + 5);

    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL pending expectations actual=%0d expected=0", expQ.size());
    end
    finish_run();
  end

endmodule